// File: doc/BRIEF.md
# Event Interrupt Controller with Held Reason Bits

This block watches a small vector of live status inputs from a link-level datapath: link state, duplex, a two-bit speed code and a configuration flag. It raises an interrupt when one of them moves away from the value last taken as an event. Each source has four bits: a pending bit, an enable bit, a write-one-to-clear bit and a held reason bit. When a source raises an event, its reason bit stores the live value of that source at that moment. A new event is detected by comparing the live value with the held reason, not by edge detection. As a result, any number of toggles that happen while an event waits for service produce one serviced event.

The live inputs pass through a two-flop synchronizer into a raw status register. In that register the link bit always follows its input. The other fields follow their inputs only while the link is up; while the link is down they keep their last values. A single interrupt output is driven from the enabled pending bits. Its active level is set by a control bit. Software reaches every register through a plain synchronous port: the address and write strobe are sampled on the clock, and read data is combinational from the address.

Top module: `evt_irq_ctrl`

## Requirements
- R1: The register addresses are 0 raw status, 1 pending, 2 enable, 3 clear, 4 reason and 5 control. Source bits are 0 link, 1 duplex, 2 and 3 speed, and 4 configuration. Read data is zero-extended.
- R2: The raw status register shows a source change three clock edges after the change at the input. The link bit always follows its input. Bits 1 to 4 are updated only while the synchronized link is 1, and otherwise keep their last values.
- R3: A source whose pending bit is 0 and whose raw value differs from its reason bit sets its pending bit on the next edge. The same edge copies the raw value into the reason bit.
- R4: While a pending bit is 1, its reason bit stays unchanged, however often the live source toggles.
- R5: Writing 1 to a clear bit clears both the pending bit and the reason bit of that source. Writing 0 to a clear bit changes nothing.
- R6: A clear bit reads as 1 for one cycle after it is written, and reads as 0 once it has been applied.
- R7: The interrupt is asserted only while some pending bit that is also enabled is set. A pending bit that is disabled stays readable and does not drive the interrupt.
- R8: Control bit 0 sets the output polarity: 1 makes the output active-high and 0 makes it active-low. Control bits 7 to 1 read back as written.
- R9: After reset, the pending, reason, enable and clear bits are 0, control reads 0x01, and the interrupt output is 0.
- R10: When a clear is applied in the same cycle as a mismatch, the clear is applied first. The pending bit reads 0 for one cycle and then sets again on the following edge, so the event is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_i | input | NUM_SRC | Live monitored status, asynchronous |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe for the register at addr |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for the register at addr |
| irq_o | output | 1 | Interrupt output with programmable polarity |

## Verification
A wrong pending or reason bit shows up at the read port and at irq_o on the edge after the mismatch that caused it. A reason bit that moves while its pending bit is held shows up as a reason readback that no longer matches the value captured when the event was taken. A clear that is applied in the wrong order against a new mismatch gives a pending readback that stays 0 for good, or that never drops to 0 for its one cycle. The bench samples the pending register in each of the two cycles after a clear write to catch either fault. A wrong hold in the raw status register shows on the first read of raw status after the link goes down.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_RAW  = 3'd0,
        REG_PEND = 3'd1,
        REG_EN   = 3'd2,
        REG_CLR  = 3'd3,
        REG_RSN  = 3'd4,
        REG_CTRL = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic pend;
        logic reason;
    } evt_state_t;

    localparam evt_state_t EVT_IDLE = '{pend: 1'b0, reason: 1'b0};

    function automatic logic drive_level(input logic active, input logic act_high);
        return act_high ? active : ~active;
    endfunction

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/eic_raw_hold.sv
module eic_raw_hold #(
    parameter int NUM_SRC  = 5,
    parameter int LINK_IDX = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] live,
    output logic [NUM_SRC-1:0] raw_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (i == LINK_IDX) begin : g_link
            always_ff @(posedge clk) begin
                if (rst) raw_q[i] <= 1'b0;
                else     raw_q[i] <= live[i];
            end
        end else begin : g_field
            always_ff @(posedge clk) begin
                if (rst)                 raw_q[i] <= 1'b0;
                else if (live[LINK_IDX]) raw_q[i] <= live[i];
            end
        end
    end
endmodule

// File: rtl/eic_event_slice.sv
module eic_event_slice
    import eic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic live,
    input  logic clr,
    output logic pend,
    output logic reason
);
    evt_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = EVT_IDLE;
        end else if (!st_q.pend && (live != st_q.reason)) begin
            st_d.pend   = 1'b1;
            st_d.reason = live;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= EVT_IDLE;
        else     st_q <= st_d;
    end

    assign pend   = st_q.pend;
    assign reason = st_q.reason;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NUM_SRC  = 5,
    parameter int DATA_W   = 8,
    parameter int LINK_IDX = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] mon_i,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq_o
);
    localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(1);

    logic [NUM_SRC-1:0] live_s;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] reason;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] clr_q;
    logic [DATA_W-1:0]  ctrl_q;
    logic               wr_clr;
    logic               any_active;

    eic_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (mon_i),
        .q_sync  (live_s)
    );

    eic_raw_hold #(.NUM_SRC(NUM_SRC), .LINK_IDX(LINK_IDX)) u_raw (
        .clk   (clk),
        .rst   (rst),
        .live  (live_s),
        .raw_q (raw_q)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        eic_event_slice u_slice (
            .clk    (clk),
            .rst    (rst),
            .live   (raw_q[i]),
            .clr    (clr_q[i]),
            .pend   (pend[i]),
            .reason (reason[i])
        );
    end

    assign wr_clr = wr_en && (reg_sel_e'(addr) == REG_CLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            clr_q  <= '0;
            ctrl_q <= CTRL_RST;
        end else begin
            clr_q <= wr_clr ? wr_data[NUM_SRC-1:0] : '0;
            if (wr_en && reg_sel_e'(addr) == REG_EN)   en_q   <= wr_data[NUM_SRC-1:0];
            if (wr_en && reg_sel_e'(addr) == REG_CTRL) ctrl_q <= wr_data;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(addr))
            REG_RAW:  rd_data = DATA_W'(raw_q);
            REG_PEND: rd_data = DATA_W'(pend);
            REG_EN:   rd_data = DATA_W'(en_q);
            REG_CLR:  rd_data = DATA_W'(clr_q);
            REG_RSN:  rd_data = DATA_W'(reason);
            REG_CTRL: rd_data = ctrl_q;
            default:  rd_data = '0;
        endcase
    end

    assign any_active = |(pend & en_q);
    assign irq_o      = drive_level(any_active, ctrl_q[0]);
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
    parameter int NUM_SRC = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_o,
    input logic               act_high,
    input logic               wr_clr,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] clr_q,
    input logic [NUM_SRC-1:0] reason,
    input logic [NUM_SRC-1:0] raw_q
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_hold_fields_R2: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !raw_q[0] |-> $stable(raw_q[NUM_SRC-1:1]));

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ((pend & ~$past(pend) & (reason ^ $past(raw_q))) == '0));

    assert_reason_frozen_R4: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ((pend & $past(pend) & (reason ^ $past(reason))) == '0));

    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (|clr_q) |=> ((pend & $past(clr_q)) == '0) && ((reason & $past(clr_q)) == '0));

    assert_clear_returns_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ((|clr_q) && !wr_clr) |=> (clr_q == '0));

    assert_quiet_when_none_R7: assert property (@(posedge clk) disable iff (rst)
        ((pend & en_q) == '0) |-> (irq_o != act_high));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_o    (irq_o),
    .act_high (ctrl_q[0]),
    .wr_clr   (wr_clr),
    .pend     (pend),
    .en_q     (en_q),
    .clr_q    (clr_q),
    .reason   (reason),
    .raw_q    (raw_q)
);

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 5;
    localparam int DW   = 8;

    typedef struct packed {
        logic [4:0] mon;
        logic       wr;
        logic [2:0] waddr;
        logic [7:0] wdata;
        logic [2:0] raddr;
        logic [7:0] exp;
        logic       irq;
    } vec_t;

    // Registers: 0 raw, 1 pend, 2 en, 3 clr, 4 reason, 5 ctrl
    localparam vec_t VEC [12] = '{
        '{5'h00, 1'b1, 3'd2, 8'h1F, 3'd2, 8'h1F, 1'b0}, // R1 enable readback
        '{5'h03, 1'b0, 3'd0, 8'h00, 3'd1, 8'h03, 1'b1}, // R3 link+duplex event
        '{5'h00, 1'b0, 3'd0, 8'h00, 3'd4, 8'h03, 1'b1}, // R4 reason frozen
        '{5'h00, 1'b0, 3'd0, 8'h00, 3'd0, 8'h02, 1'b1}, // R2 duplex held, link down
        '{5'h00, 1'b1, 3'd3, 8'h01, 3'd1, 8'h02, 1'b1}, // R5 clear link only
        '{5'h00, 1'b1, 3'd3, 8'h02, 3'd1, 8'h02, 1'b1}, // R5/R3 duplex re-raised
        '{5'h00, 1'b1, 3'd2, 8'h01, 3'd1, 8'h02, 1'b0}, // R7 disabled still pending
        '{5'h00, 1'b0, 3'd0, 8'h00, 3'd3, 8'h00, 1'b0}, // R6 clear reads 0
        '{5'h00, 1'b1, 3'd5, 8'hA4, 3'd5, 8'hA4, 1'b1}, // R8 active-low, idle high
        '{5'h01, 1'b0, 3'd0, 8'h00, 3'd4, 8'h03, 1'b0}, // R3/R8 link up, asserted low
        '{5'h01, 1'b1, 3'd3, 8'h00, 3'd1, 8'h03, 1'b0}, // R5 zero write no effect
        '{5'h01, 1'b1, 3'd5, 8'h01, 3'd0, 8'h01, 1'b1}  // R2/R8 duplex updated, high
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] mon_i = '0;
    logic [2:0]      addr = '0;
    logic            wr_en = 1'b0;
    logic [DW-1:0]   wr_data = '0;
    logic [DW-1:0]   rd_data;
    logic            irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_ctrl i_evt_irq_ctrl (
        .clk     (clk),
        .rst     (rst),
        .mon_i   (mon_i),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_o   (irq_o)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_at(input logic [2:0] a, output logic [DW-1:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        read_at(3'd1, d); check("R9 pend", d, 8'h00);
        read_at(3'd4, d); check("R9 reason", d, 8'h00);
        read_at(3'd2, d); check("R9 enable", d, 8'h00);
        read_at(3'd3, d); check("R9 clear", d, 8'h00);
        read_at(3'd5, d); check("R9 ctrl", d, 8'h01);
        check("R9 irq", {7'b0, irq_o}, 8'h00);

        foreach (VEC[v]) begin
            mon_i = VEC[v].mon;
            if (VEC[v].wr) do_write(VEC[v].waddr, VEC[v].wdata);
            idle(6);
            read_at(VEC[v].raddr, d);
            check($sformatf("R1 vector %0d data", v), d, VEC[v].exp);
            check($sformatf("R7 vector %0d irq", v), {7'b0, irq_o}, {7'b0, VEC[v].irq});
        end

        // R4: link toggles while bit 0 is pending with reason 1
        mon_i = 5'h00; idle(3);
        mon_i = 5'h01; idle(2);
        mon_i = 5'h00; idle(6);
        read_at(3'd4, d); check("R4 reason after toggles", d, 8'h03);
        mon_i = 5'h01; idle(6);

        // R6 / R10: clear bit 0 while raw link is 1
        @(negedge clk);
        addr = 3'd3; wr_data = 8'h01; wr_en = 1'b1;
        @(negedge clk);          // write taken on the edge in between
        wr_en = 1'b0;
        read_at(3'd3, d); check("R6 clear visible", d, 8'h01);
        @(negedge clk);          // clear applied
        read_at(3'd3, d); check("R6 clear returned", d, 8'h00);
        read_at(3'd1, d); check("R10 pend dropped", d & 8'h01, 8'h00);
        read_at(3'd4, d); check("R5 reason cleared", d & 8'h01, 8'h00);
        @(negedge clk);          // mismatch re-raises
        read_at(3'd1, d); check("R10 pend re-raised", d & 8'h01, 8'h01);
        read_at(3'd4, d); check("R3 reason recaptured", d & 8'h01, 8'h01);

        // R9 again: reset mid-run
        rst = 1'b1; idle(2); rst = 1'b0; mon_i = '0;
        @(negedge clk);
        check("R9 irq after reset", {7'b0, irq_o}, 8'h00);
        read_at(3'd1, d); check("R9 pend after reset", d, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule